// File: doc/BRIEF.md
# Single-Accumulator Minicomputer Core

This block is a compact 16-bit processor built around one accumulator. It has a 12-bit program counter. It fetches instruction and data words through a synchronous single-port memory interface: an address presented in one clock returns its data in the next. Arithmetic is two's complement. The word is numbered with the most significant bit as bit 0, and every field below is also given as a `[15:0]` vector slice.

A memory-reference word carries an indirect flag in its top bit, a three-bit opcode and a 12-bit address. Opcode 111 opens an operate group. That group covers clear, complement, shifts, rotates, the accumulator and overflow skips, the interrupt mask controls, interrupt return, halt, and the two direct I/O transfers. A single interrupt line is latched while masked and taken at the next instruction boundary once unmasked.

The control is one finite-state machine. FETCH presents the PC and moves to DECODE, except that it stays in FETCH for one clock when it takes an interrupt. DECODE latches the word. An operate word completes in DECODE and returns to FETCH. DIN goes to DINW, and HLT goes to HALT. A direct memory-reference word goes to EXEC, and an indirect one goes to INDIR. INDIR stays in INDIR while each pointer word it reads has its top bit set, and otherwise goes to EXEC. EXEC returns to FETCH for STA, JMP and JSR, and goes to READ for LDA, ADD, AND and IAS. READ returns to FETCH, and so does DINW. HALT returns to FETCH only on `run`.

Top module: `acc_core`

## Requirements
- R1: While reset is held and in the first clock after it, the core presents address 0. It asserts neither memory write nor any I/O strobe, `halted` is low, and interrupts are masked.
- R2: Memory-reference words are `{ind[15], op[14:12], addr[11:0]}` with LDA=000, JMP=001, ADD=010, JSR=011, AND=100, STA=101, IAS=110. LDA loads the accumulator from memory. AND combines it bitwise with memory. STA writes it to memory. The memory write enable is asserted only in EXEC or READ.
- R3: ADD adds memory to the accumulator and sets overflow to the signed overflow of that sum. Overflow then holds through all other instructions until the next ADD, IAS or CLA.
- R4: With `ind` set, the address field names a pointer word whose bits [11:0] give the next address. If the pointer's bit 15 is also set, indirection repeats, one extra clock per level.
- R5: JMP loads the PC with the effective address. JSR writes the address of the following instruction into the effective address, continues at effective address plus 1, and clears the accumulator.
- R6: IAS reads the word, adds 1, writes the result back, and leaves it in the accumulator with overflow set by that increment. It skips the next instruction when the result is zero.
- R7: Operate words are `{hi[15], 111, sel[11:8], mid[7:4], n[3:0]}`. The selections are SAL {0,0000}, which shifts left by n with zero fill; RAL {1,0000}, which rotates left by n with the top bit wrapping to the bottom; CLA {0,0001}, which clears the accumulator and overflow; and CMP {1,0001}, which gives the two's complement negation.
- R8: The skip selections are SAZ {0,0100}, which skips on a zero accumulator; SNZ {1,0100}, which skips on nonzero; SNO {0,0101}, which skips when overflow is clear; and SAC {1,0101}, which skips when accumulator bit n is 1, with bit 0 as the MSB (vector bit 15-n). A skip advances the PC by 2.
- R9: DOT {0,1000} drives `io_dev`=mid and `io_fn`=n, puts the accumulator on `io_out`, and pulses `io_wstb` for one clock. DIN {1,1000} pulses `io_rstb` with the same fields, and the accumulator takes `io_in` on the following clock. The two strobes are never asserted together.
- R10: MSK {0,0010} masks interrupts, and UNM {1,0010} unmasks them. A high `irq` is remembered as pending. A pending interrupt is taken only while unmasked and at FETCH: the core saves PC, accumulator and overflow, masks interrupts, and continues at `IRQ_VEC`.
- R11: RTI {0,0011} restores the saved PC, accumulator and overflow and unmasks interrupts.
- R12: HLT {0,1001} enters HALT, raising `halted`. The core stays there with the PC unchanged until `run` is high, then resumes at the next instruction.
- R13: Clock counts are: operate 2, STA/JMP/JSR 3, DIN 3, and LDA/ADD/AND/IAS 4, plus 1 per indirect level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one clock after address |
| io_dev | output | 4 | I/O device select |
| io_fn | output | 4 | I/O function code |
| io_out | output | 16 | Output data bus (accumulator) |
| io_wstb | output | 1 | Output transfer strobe |
| io_rstb | output | 1 | Input transfer strobe |
| io_in | input | 16 | Input data bus |
| irq | input | 1 | Interrupt request |
| run | input | 1 | Resume from halt |
| halted | output | 1 | Core is in HALT |

## Verification
The bench runs one program that reaches every opcode and every operate selection, and reports each result through a DOT. The first corner is signed overflow at 7FFF+1, which is then tested by SNO both before and after CLA. A core that dropped or cleared overflow early would emit an extra DOT on device 2, or lose one. Other targets are IAS wrapping FFFF to zero, where a missing skip leaks a device-2 DOT, and two-level indirection, where a core stopping after one level loads the pointer instead of the data. The JSR return word is checked in memory, as is the A+1 entry point, which reports a cleared accumulator. The interrupt is raised while masked. Taking it before UNM, or failing to restore the accumulator afterwards, reorders or corrupts the logged DOTs. The bench also times the first DOT and checks that HLT holds until `run`.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef enum logic [2:0] {
        ST_FETCH, ST_DECODE, ST_INDIR, ST_EXEC, ST_READ, ST_DINW, ST_HALT
    } state_t;

    typedef enum logic [2:0] {
        ALU_PASS, ALU_ADD, ALU_AND, ALU_INC, ALU_SHL, ALU_ROL, ALU_NEG
    } alu_fn_t;

    typedef enum logic [2:0] {
        SK_NONE, SK_ZERO, SK_NZ, SK_NOOV, SK_BIT
    } skip_t;

    localparam logic [2:0] OP_LDA = 3'b000;
    localparam logic [2:0] OP_JMP = 3'b001;
    localparam logic [2:0] OP_ADD = 3'b010;
    localparam logic [2:0] OP_JSR = 3'b011;
    localparam logic [2:0] OP_AND = 3'b100;
    localparam logic [2:0] OP_STA = 3'b101;
    localparam logic [2:0] OP_IAS = 3'b110;
    localparam logic [2:0] OP_OPR = 3'b111;

    // operate selection = {top bit, bits [11:8]}
    localparam logic [4:0] X_SAL = 5'b0_0000;
    localparam logic [4:0] X_RAL = 5'b1_0000;
    localparam logic [4:0] X_CLA = 5'b0_0001;
    localparam logic [4:0] X_CMP = 5'b1_0001;
    localparam logic [4:0] X_MSK = 5'b0_0010;
    localparam logic [4:0] X_UNM = 5'b1_0010;
    localparam logic [4:0] X_RTI = 5'b0_0011;
    localparam logic [4:0] X_SAZ = 5'b0_0100;
    localparam logic [4:0] X_SNZ = 5'b1_0100;
    localparam logic [4:0] X_SNO = 5'b0_0101;
    localparam logic [4:0] X_SAC = 5'b1_0101;
    localparam logic [4:0] X_DOT = 5'b0_1000;
    localparam logic [4:0] X_DIN = 5'b1_1000;
    localparam logic [4:0] X_HLT = 5'b0_1001;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   n,
    input  alu_fn_t      fn,
    output logic [W-1:0] y,
    output logic         v
);
    logic [W-1:0] sum;
    logic [W-1:0] addend;

    always_comb begin
        addend = (fn == ALU_INC) ? {{(W-1){1'b0}}, 1'b1} : a;
        sum    = addend + b;
    end

    always_comb begin
        y = b;
        v = 1'b0;
        unique case (fn)
            ALU_PASS: y = b;
            ALU_ADD, ALU_INC: begin
                y = sum;
                v = (addend[W-1] == b[W-1]) && (sum[W-1] != b[W-1]);
            end
            ALU_AND:  y = a & b;
            ALU_SHL:  y = a << n;
            ALU_ROL:  y = (a << n) | (a >> (W - int'(n)));
            ALU_NEG:  y = ~a + 1'b1;
            default:  y = b;
        endcase
    end
endmodule

// File: rtl/acc_skip.sv
module acc_skip
    import acc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic         ov,
    input  skip_t        sel,
    input  logic [3:0]   bsel,
    output logic         skip
);
    localparam int BW = $clog2(W);
    logic [BW-1:0] idx;

    always_comb begin
        idx  = BW'(W - 1) - BW'(bsel);
        skip = 1'b0;
        unique case (sel)
            SK_NONE: skip = 1'b0;
            SK_ZERO: skip = (a == '0);
            SK_NZ:   skip = (a != '0);
            SK_NOOV: skip = !ov;
            SK_BIT:  skip = a[idx];
            default: skip = 1'b0;
        endcase
    end
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
#(
    parameter int AW      = 12,
    parameter int IRQ_VEC = 240
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_we,
    output logic [AW+3:0]   mem_wdata,
    input  logic [AW+3:0]   mem_rdata,
    output logic [3:0]      io_dev,
    output logic [3:0]      io_fn,
    output logic [AW+3:0]   io_out,
    output logic            io_wstb,
    output logic            io_rstb,
    input  logic [AW+3:0]   io_in,
    input  logic            irq,
    input  logic            run,
    output logic            halted
);
    localparam int DW = AW + 4;
    localparam logic [AW-1:0] VEC = AW'(IRQ_VEC);

    state_t        state, nstate;
    logic [AW-1:0] pc, ea, sh_pc;
    logic [DW-1:0] acc, ir, sh_acc;
    logic          ov, sh_ov, mask, pend;

    logic [DW-1:0] cur;
    logic          c_ind;
    logic [2:0]    c_op;
    logic [AW-1:0] c_addr;
    logic [4:0]    c_sel;
    logic          take_irq;

    alu_fn_t       alu_fn;
    logic [DW-1:0] alu_y;
    logic          alu_v;
    skip_t         sk_sel;
    logic          skip;

    assign cur      = (state == ST_DECODE) ? mem_rdata : ir;
    assign c_ind    = cur[DW-1];
    assign c_op     = cur[DW-2:DW-4];
    assign c_addr   = cur[AW-1:0];
    assign c_sel    = {cur[DW-1], cur[11:8]};
    assign take_irq = pend && !mask;

    acc_alu #(.W(DW)) u_alu (
        .a(acc), .b(mem_rdata), .n(cur[3:0]), .fn(alu_fn), .y(alu_y), .v(alu_v)
    );

    acc_skip #(.W(DW)) u_skip (
        .a(acc), .ov(ov), .sel(sk_sel), .bsel(cur[3:0]), .skip(skip)
    );

    // function selection for the datapath helpers
    always_comb begin
        alu_fn = ALU_PASS;
        sk_sel = SK_NONE;
        if (state == ST_DECODE && c_op == OP_OPR) begin
            case (c_sel)
                X_SAL:   alu_fn = ALU_SHL;
                X_RAL:   alu_fn = ALU_ROL;
                X_CMP:   alu_fn = ALU_NEG;
                X_SAZ:   sk_sel = SK_ZERO;
                X_SNZ:   sk_sel = SK_NZ;
                X_SNO:   sk_sel = SK_NOOV;
                X_SAC:   sk_sel = SK_BIT;
                default: ;
            endcase
        end else if (state == ST_READ) begin
            case (c_op)
                OP_ADD:  alu_fn = ALU_ADD;
                OP_AND:  alu_fn = ALU_AND;
                OP_IAS:  alu_fn = ALU_INC;
                default: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= nstate;
    end

    // next state and outputs
    always_comb begin
        nstate    = state;
        mem_addr  = pc;
        mem_we    = 1'b0;
        mem_wdata = acc;
        io_wstb   = 1'b0;
        io_rstb   = 1'b0;
        unique case (state)
            ST_FETCH:  nstate = take_irq ? ST_FETCH : ST_DECODE;
            ST_DECODE: begin
                if (c_op == OP_OPR) begin
                    nstate = ST_FETCH;
                    case (c_sel)
                        X_DOT: io_wstb = 1'b1;
                        X_DIN: begin
                            io_rstb = 1'b1;
                            nstate  = ST_DINW;
                        end
                        X_HLT:   nstate = ST_HALT;
                        default: ;
                    endcase
                end else if (c_ind) begin
                    mem_addr = c_addr;
                    nstate   = ST_INDIR;
                end else begin
                    nstate = ST_EXEC;
                end
            end
            ST_INDIR: begin
                if (mem_rdata[DW-1]) begin
                    mem_addr = mem_rdata[AW-1:0];
                    nstate   = ST_INDIR;
                end else begin
                    nstate = ST_EXEC;
                end
            end
            ST_EXEC: begin
                nstate = ST_FETCH;
                case (c_op)
                    OP_LDA, OP_ADD, OP_AND, OP_IAS: begin
                        mem_addr = ea;
                        nstate   = ST_READ;
                    end
                    OP_STA: begin
                        mem_addr = ea;
                        mem_we   = 1'b1;
                    end
                    OP_JSR: begin
                        mem_addr  = ea;
                        mem_we    = 1'b1;
                        mem_wdata = {{(DW-AW){1'b0}}, pc};
                    end
                    default: ;
                endcase
            end
            ST_READ: begin
                nstate = ST_FETCH;
                if (c_op == OP_IAS) begin
                    mem_addr  = ea;
                    mem_we    = 1'b1;
                    mem_wdata = alu_y;
                end
            end
            ST_DINW:   nstate = ST_FETCH;
            ST_HALT:   nstate = run ? ST_FETCH : ST_HALT;
            default:   nstate = ST_FETCH;
        endcase
    end

    assign io_dev = cur[7:4];
    assign io_fn  = cur[3:0];
    assign io_out = acc;
    assign halted = (state == ST_HALT);

    // architectural registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc     <= '0;
            acc    <= '0;
            ov     <= 1'b0;
            mask   <= 1'b1;
            pend   <= 1'b0;
            ir     <= '0;
            ea     <= '0;
            sh_pc  <= '0;
            sh_acc <= '0;
            sh_ov  <= 1'b0;
        end else begin
            if (irq) pend <= 1'b1;
            unique case (state)
                ST_FETCH: begin
                    if (take_irq) begin
                        sh_pc  <= pc;
                        sh_acc <= acc;
                        sh_ov  <= ov;
                        pc     <= VEC;
                        mask   <= 1'b1;
                        pend   <= 1'b0;
                    end
                end
                ST_DECODE: begin
                    ir <= mem_rdata;
                    ea <= c_addr;
                    pc <= pc + 1'b1;
                    if (c_op == OP_OPR) begin
                        case (c_sel)
                            X_SAL, X_RAL, X_CMP: acc <= alu_y;
                            X_CLA: begin
                                acc <= '0;
                                ov  <= 1'b0;
                            end
                            X_SAZ, X_SNZ, X_SNO, X_SAC:
                                if (skip) pc <= pc + 2'd2;
                            X_MSK: mask <= 1'b1;
                            X_UNM: mask <= 1'b0;
                            X_RTI: begin
                                pc   <= sh_pc;
                                acc  <= sh_acc;
                                ov   <= sh_ov;
                                mask <= 1'b0;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_INDIR: ea <= mem_rdata[AW-1:0];
                ST_EXEC: begin
                    if (c_op == OP_JMP) pc <= ea;
                    if (c_op == OP_JSR) begin
                        pc  <= ea + 1'b1;
                        acc <= '0;
                    end
                end
                ST_READ: begin
                    case (c_op)
                        OP_LDA: acc <= mem_rdata;
                        OP_AND: acc <= alu_y;
                        OP_ADD: begin
                            acc <= alu_y;
                            ov  <= alu_v;
                        end
                        OP_IAS: begin
                            acc <= alu_y;
                            ov  <= alu_v;
                            if (alu_y == '0) pc <= pc + 1'b1;
                        end
                        default: ;
                    endcase
                end
                ST_DINW: acc <= io_in;
                ST_HALT: ;
                default: ;
            endcase
        end
    end

    // ---------------- assertions ----------------
    assert_we_states_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (state == ST_EXEC || state == ST_READ));

    assert_add_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && ir[DW-2:DW-4] == OP_ADD) |=>
        (ov == ((!$past(acc[DW-1]) && !$past(mem_rdata[DW-1]) && acc[DW-1]) ||
                ($past(acc[DW-1]) && $past(mem_rdata[DW-1]) && !acc[DW-1]))));

    assert_rol_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE && c_op == OP_OPR && c_sel == X_RAL) |=>
        ($countones(acc) == $countones($past(acc))));

    assert_din_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DINW) |=> (acc == $past(io_in)));

    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wstb && io_rstb));

    assert_irq_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH && pend && !mask) |=> (pc == VEC && mask));

    assert_masked_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH && mask) |=> (state == ST_DECODE));

    assert_halt_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !run) |=> (state == ST_HALT && $stable(pc)));

endmodule

// File: tb/sim_acc_core.sv
module sim_acc_core;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] mem_addr;
    logic        mem_we;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic [3:0]  io_dev, io_fn;
    logic [15:0] io_out;
    logic        io_wstb, io_rstb;
    logic [15:0] io_in;
    logic        irq, run, halted;

    always #10 clk = ~clk;

    acc_core u0 (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .io_dev(io_dev),
        .io_fn(io_fn), .io_out(io_out), .io_wstb(io_wstb), .io_rstb(io_rstb),
        .io_in(io_in), .irq(irq), .run(run), .halted(halted)
    );

    // memory model: one-clock read latency
    logic [15:0] mem [256];
    logic        tb_we;
    logic [7:0]  tb_addr;
    logic [15:0] tb_data;
    always @(posedge clk) begin
        if (tb_we)       mem[tb_addr] <= tb_data;
        else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[7:0]];
    end

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int first_cyc = -1;
    int ndot = 0;
    logic [3:0]  dot_dev [32];
    logic [3:0]  dot_fn  [32];
    logic [15:0] dot_val [32];
    logic [3:0]  din_dev, din_fn;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        if (rst_n && io_wstb && ndot < 32) begin
            if (ndot == 0) first_cyc = cyc;
            dot_dev[ndot] = io_dev;
            dot_fn[ndot]  = io_fn;
            dot_val[ndot] = io_out;
            ndot = ndot + 1;
        end
        if (rst_n && io_rstb) begin
            din_dev = io_dev;
            din_fn  = io_fn;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mref(input logic i, input logic [2:0] op, input logic [11:0] a);
        return {i, op, a};
    endfunction

    function automatic logic [15:0] opr(input logic hi, input logic [3:0] sel,
                                        input logic [3:0] mid, input logic [3:0] n);
        return {hi, 3'b111, sel, mid, n};
    endfunction

    task automatic poke(input int a, input logic [15:0] d);
        tb_addr = a[7:0];
        tb_data = d;
        tb_we   = 1'b1;
        @(negedge clk);
        tb_we   = 1'b0;
    endtask

    task automatic wait_halt(input string tag);
        for (int k = 0; k < 5000 && !halted; k++) @(negedge clk);
        if (!halted) begin
            checks++;
            errors++;
            $display("FAIL %s watchdog: halted actual=0 expected=1", tag);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v_add, v_and, v_sal, v_ral, v_cmp, v_i0, v_i1;
        logic [3:0]  e_dev [15];
        logic [3:0]  e_fn  [15];
        logic [15:0] e_val [15];
        string       e_tag [15];

        rst_n = 1'b0; irq = 1'b0; run = 1'b0; tb_we = 1'b0;
        tb_addr = '0; tb_data = '0; io_in = 16'hA5C3;
        @(negedge clk);

        // program
        poke(0,  mref(0, 3'b000, 12'h040));   // LDA 40
        poke(1,  mref(0, 3'b010, 12'h041));   // ADD 41
        poke(2,  opr(0, 4'h8, 4'd1, 4'd0));   // DOT
        poke(3,  opr(0, 4'h5, 4'd0, 4'd0));   // SNO
        poke(4,  opr(0, 4'h8, 4'd1, 4'd1));   // DOT
        poke(5,  opr(0, 4'h1, 4'd0, 4'd0));   // CLA
        poke(6,  opr(0, 4'h5, 4'd0, 4'd0));   // SNO
        poke(7,  opr(0, 4'h8, 4'd2, 4'd0));   // DOT (skipped)
        poke(8,  mref(0, 3'b000, 12'h042));   // LDA 42
        poke(9,  mref(0, 3'b100, 12'h043));   // AND 43
        poke(10, opr(0, 4'h8, 4'd1, 4'd2));
        poke(11, opr(0, 4'h0, 4'd0, 4'd4));   // SAL 4
        poke(12, opr(0, 4'h8, 4'd1, 4'd3));
        poke(13, opr(1, 4'h0, 4'd0, 4'd4));   // RAL 4
        poke(14, opr(0, 4'h8, 4'd1, 4'd4));
        poke(15, opr(1, 4'h1, 4'd0, 4'd0));   // CMP
        poke(16, opr(0, 4'h8, 4'd1, 4'd5));
        poke(17, opr(1, 4'h5, 4'd0, 4'd0));   // SAC 0
        poke(18, opr(0, 4'h8, 4'd2, 4'd1));   // skipped
        poke(19, mref(0, 3'b101, 12'h044));   // STA 44
        poke(20, opr(0, 4'h1, 4'd0, 4'd0));   // CLA
        poke(21, mref(1, 3'b000, 12'h045));   // LDA I 45 (two levels)
        poke(22, opr(0, 4'h8, 4'd1, 4'd6));
        poke(23, mref(0, 3'b110, 12'h046));   // IAS 46
        poke(24, opr(0, 4'h8, 4'd2, 4'd2));   // skipped
        poke(25, opr(0, 4'h8, 4'd1, 4'd7));
        poke(26, mref(0, 3'b110, 12'h047));   // IAS 47
        poke(27, opr(0, 4'h8, 4'd1, 4'd8));
        poke(28, mref(0, 3'b011, 12'h050));   // JSR 50
        poke(29, opr(0, 4'h8, 4'd1, 4'd10));
        poke(30, opr(1, 4'h8, 4'd3, 4'd4));   // DIN dev3 fn4
        poke(31, opr(0, 4'h8, 4'd1, 4'd11));
        poke(32, opr(0, 4'h4, 4'd0, 4'd0));   // SAZ
        poke(33, opr(1, 4'h4, 4'd0, 4'd0));   // SNZ
        poke(34, opr(0, 4'h8, 4'd2, 4'd3));   // skipped
        poke(35, opr(1, 4'h2, 4'd0, 4'd0));   // UNM
        poke(36, opr(0, 4'h8, 4'd1, 4'd12));
        poke(37, opr(0, 4'h9, 4'd0, 4'd0));   // HLT
        poke(38, opr(0, 4'h8, 4'd1, 4'd13));
        poke(39, opr(0, 4'h9, 4'd0, 4'd0));   // HLT
        poke(8'h40, 16'h7FFF);
        poke(8'h41, 16'h0001);
        poke(8'h42, 16'h1234);
        poke(8'h43, 16'h0FF0);
        poke(8'h44, 16'h0000);
        poke(8'h45, 16'h8049);
        poke(8'h46, 16'hFFFF);
        poke(8'h47, 16'h0005);
        poke(8'h48, 16'h5555);
        poke(8'h49, 16'h0044);
        poke(8'h50, 16'h0000);
        poke(8'h51, opr(0, 4'h8, 4'd1, 4'd9));
        poke(8'h52, mref(0, 3'b000, 12'h042));
        poke(8'h53, mref(1, 3'b001, 12'h050)); // JMP I 50
        poke(8'hF0, mref(0, 3'b000, 12'h048));
        poke(8'hF1, opr(0, 4'h8, 4'd5, 4'd0));
        poke(8'hF2, opr(0, 4'h3, 4'd0, 4'd0)); // RTI

        // R1: reset state
        chk("R1 mem_addr in reset", 32'(mem_addr), 32'h0);
        chk("R1 mem_we in reset", 32'(mem_we), 32'h0);
        chk("R1 strobes in reset", 32'({io_wstb, io_rstb}), 32'h0);
        chk("R1 halted in reset", 32'(halted), 32'h0);
        rst_n = 1'b1;
        chk("R1 first fetch address", 32'(mem_addr), 32'h0);
        @(negedge clk);
        irq = 1'b1;      // raised while masked: must wait for UNM
        @(negedge clk);
        irq = 1'b0;

        wait_halt("R12 first halt");

        v_add = 16'h7FFF + 16'h0001;
        v_and = 16'h1234 & 16'h0FF0;
        v_sal = v_and << 4;
        v_ral = (v_sal << 4) | (v_sal >> 12);
        v_cmp = ~v_ral + 16'h0001;
        v_i0  = 16'hFFFF + 16'h0001;
        v_i1  = 16'h0005 + 16'h0001;

        e_dev = '{4'd1, 4'd1, 4'd1, 4'd1, 4'd1, 4'd1, 4'd1, 4'd1,
                  4'd1, 4'd1, 4'd1, 4'd1, 4'd5, 4'd1, 4'd1};
        e_fn  = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7,
                  4'd8, 4'd9, 4'd10, 4'd11, 4'd0, 4'd12, 4'd13};
        e_val = '{v_add, v_add, v_and, v_sal, v_ral, v_cmp, v_cmp, v_i0,
                  v_i1, 16'h0000, 16'h1234, 16'hA5C3, 16'h5555, 16'hA5C3, 16'hA5C3};
        e_tag = '{"R3 add overflow", "R3 R8 SNO with overflow set", "R2 AND",
                  "R7 SAL", "R7 RAL", "R7 CMP", "R4 two-level indirect after STA",
                  "R6 IAS wrap skip", "R6 IAS no skip", "R5 JSR clears acc",
                  "R5 return via JMP I", "R9 DIN load", "R10 handler runs after UNM",
                  "R11 RTI restores acc", "R12 resume after run"};

        chk("R13 first DOT clock", 32'(first_cyc), 32'(4 + 4 + 2 - 1));
        chk("R8 DOT count before run (skips)", 32'(ndot), 32'd14);
        for (int i = 0; i < 14; i++) begin
            chk({e_tag[i], " dev/fn"}, 32'({dot_dev[i], dot_fn[i]}), 32'({e_dev[i], e_fn[i]}));
            chk({e_tag[i], " value"}, 32'(dot_val[i]), 32'(e_val[i]));
        end
        chk("R9 DIN dev/fn", 32'({din_dev, din_fn}), 32'h34);
        chk("R2 STA word", 32'(mem[8'h44]), 32'(v_cmp));
        chk("R6 IAS write-back wrap", 32'(mem[8'h46]), 32'(v_i0));
        chk("R6 IAS write-back", 32'(mem[8'h47]), 32'(v_i1));
        chk("R5 JSR linkage word", 32'(mem[8'h50]), 32'd29);

        repeat (30) @(negedge clk);
        chk("R12 still halted", 32'(halted), 32'h1);
        chk("R12 no DOT while halted", 32'(ndot), 32'd14);

        run = 1'b1;
        @(negedge clk);
        run = 1'b0;
        for (int k = 0; k < 50 && halted; k++) @(negedge clk);
        wait_halt("R12 second halt");
        chk("R12 DOT count after run", 32'(ndot), 32'd15);
        chk({e_tag[14], " dev/fn"}, 32'({dot_dev[14], dot_fn[14]}), 32'({e_dev[14], e_fn[14]}));
        chk({e_tag[14], " value"}, 32'(dot_val[14]), 32'(e_val[14]));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule